// File: doc/BRIEF.md
# Scaler Step and Tile Offset Calculator

This block turns one line's source length and target length into the values that program an image scaler: a fixed-point step on a 2^15 grid, an integer start offset, a subpixel start offset, and the input and output lengths of each tile. A single pulse on `start_i` launches a computation. Some cycles later `done_o` pulses for one cycle, with the parameter outputs valid. The outputs then hold until the next result.

The step is the ratio of the two lengths, rounded up. The first output sample is centred by halving the rounding error the step leaves over the whole line. In dual-tile mode the line is split into a left and a right half that are scaled separately. Each half takes a 4-pixel overlap. The right half gets its own start offset, whose integer part is forced even. The division runs in a one-bit-per-cycle restoring divider. All other arithmetic is done in a single cycle after the quotient is ready.

Top module: `scl_tile_calc`

## Requirements
- R1: `step_o` equals floor((32768*(in_len-1) + out_len-2) / (out_len-1)), computed in 32-bit unsigned arithmetic.
- R2: When `out_len_i` is 0 or 1, the result pulses `done_o` and `err_o` together, and every parameter output reads zero.
- R3: The left offset is formed from a centring value off = trunc((step*(out_len-1) - 32768*(in_len-1)) / 2). The left subpixel value is -off, brought into [0, 32768) by borrowing one from an integer part that starts at 0. With the usual off in [0, 32768), this gives `l_int_o` = 0xFFFF and `l_sub_o` = 32768-off when off is nonzero, and both zero when off is zero.
- R4: With `dual_i` = 0 (single tile), `l_in_o` = in_len and `l_out_o` = out_len, and every right-tile output reads zero.
- R5: With `dual_i` = 1, `l_in_o` = in_len/2 + 4, and both `l_out_o` and `r_out_o` equal out_len/2 (integer halves).
- R6: In dual mode, let c = 1 when off is nonzero and 0 otherwise. Let o = 32768 - off + (out_len/2)*step - (in_len/2 - 4 - c + 1)*32768 + 32768 as a signed 32-bit value. Then the right integer part is o/32768 truncated toward zero, the right subpixel part is o - 32768*(that integer part), and `r_in_o` = in_len/2 + 4 + c. When the integer part is odd, both it and `r_in_o` are increased by one.
- R7: The integer offsets are emitted as their low 16 bits (two's complement) and the subpixel offsets as their low 21 bits.
- R8: `busy_o` is high from the cycle after an accepted start until the done cycle. It falls in the cycle where `done_o` pulses. A start pulse while `busy_o` is high is ignored and produces no result. After reset, `busy_o`, `done_o` and `err_o` are low and the parameter outputs are zero.
- R9: The parameter outputs change only in a cycle where `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch pulse, taken only while idle |
| in_len_i | input | 16 | Frame input length in pixels |
| out_len_i | input | 16 | Frame output length in pixels |
| dual_i | input | 1 | 1 = split into left/right tiles, 0 = single tile |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | One-cycle result pulse |
| err_o | output | 1 | Result rejected (output length below 2), valid with done_o |
| step_o | output | 32 | Scaling step on a 2^15 grid |
| l_int_o | output | 16 | Left/single tile integer offset |
| l_sub_o | output | 21 | Left/single tile subpixel offset |
| l_in_o | output | 17 | Left/single tile input length |
| l_out_o | output | 16 | Left/single tile output length |
| r_int_o | output | 16 | Right tile integer offset |
| r_sub_o | output | 21 | Right tile subpixel offset |
| r_in_o | output | 17 | Right tile input length |
| r_out_o | output | 16 | Right tile output length |

## Verification
The hardest case to reach from the ports is the even-forcing correction on the right tile. It fires only when a particular mix of lengths, step and centring carry makes the right integer offset odd. The stimulus covers it with hand-picked pairs that are known to hit it, such as identical 7-to-7 dual lengths, and adds a run of pseudo-random dual-mode pairs that land on both parities. A start pulse given in the middle of a divide, with different operands, checks that the result still belongs to the first request and that no second result appears.

// File: rtl/scl_tile_pkg.sv
package scl_tile_pkg;
  parameter int LEN_W  = 16;
  parameter int WORD_W = 32;
  parameter int FRAC_W = 15;
  parameter int INT_W  = 16;
  parameter int SUB_W  = 21;
  parameter int OVL    = 4;

  typedef struct packed {
    logic [INT_W-1:0] int_off;
    logic [SUB_W-1:0] sub_off;
    logic [LEN_W:0]   in_len;
    logic [LEN_W-1:0] out_len;
  } tile_t;

  // signed halving, rounding toward zero
  function automatic logic signed [WORD_W-1:0] half_tz(input logic signed [WORD_W-1:0] x);
    logic signed [WORD_W-1:0] q;
    q = x >>> 1;
    if (x[WORD_W-1] && x[0]) q = q + 1;
    return q;
  endfunction

  // signed division by 2^FRAC_W, rounding toward zero
  function automatic logic signed [WORD_W-1:0] unit_div_tz(input logic signed [WORD_W-1:0] x);
    logic signed [WORD_W-1:0] q;
    logic [FRAC_W-1:0]        low;
    q   = x >>> FRAC_W;
    low = x[FRAC_W-1:0];
    if (x[WORD_W-1] && (low != '0)) q = q + 1;
    return q;
  endfunction
endpackage

// File: rtl/scl_iter_div.sv
module scl_iter_div #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         go_i,
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  output logic [W-1:0] quo_o,
  output logic         valid_o
);
  localparam int CW = $clog2(W + 1);

  logic [W:0]   rem_q;
  logic [W-1:0] quo_q, den_q, num_q;
  logic [CW-1:0] cnt_q;
  logic         run_q;
  logic [W:0]   rem_sh;
  logic         fits;

  assign rem_sh = {rem_q[W-1:0], quo_q[W-1]};
  assign fits   = rem_sh >= {1'b0, den_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0; quo_q <= '0; den_q <= '0; num_q <= '0;
      cnt_q <= '0; run_q <= 1'b0; valid_o <= 1'b0;
    end else if (go_i) begin
      rem_q <= '0; quo_q <= num_i; num_q <= num_i; den_q <= den_i;
      cnt_q <= CW'(W); run_q <= 1'b1; valid_o <= 1'b0;
    end else if (run_q) begin
      rem_q <= fits ? (rem_sh - {1'b0, den_q}) : rem_sh;
      quo_q <= {quo_q[W-2:0], fits};
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CW'(1)) begin
        run_q   <= 1'b0;
        valid_o <= 1'b1;
      end
    end else begin
      valid_o <= 1'b0;
    end
  end

  assign quo_o = quo_q;

  logic [2*W-1:0] prod_chk, num_w, den_w;
  assign prod_chk = {{W{1'b0}}, quo_q} * {{W{1'b0}}, den_q};
  assign num_w    = {{W{1'b0}}, num_q};
  assign den_w    = {{W{1'b0}}, den_q};

  AST_QUOTIENT_EXACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (prod_chk <= num_w) && ((num_w - prod_chk) < den_w)); // R1
endmodule

// File: rtl/scl_phase_calc.sv
module scl_phase_calc
  import scl_tile_pkg::*;
(
  input  logic [LEN_W-1:0]  in_len_i,
  input  logic [LEN_W-1:0]  out_len_i,
  input  logic [WORD_W-1:0] step_i,
  input  logic              dual_i,
  output tile_t             left_o,
  output tile_t             right_o,
  output logic              centre_nz_o
);
  localparam logic signed [WORD_W-1:0] UNIT = WORD_W'(1) <<< FRAC_W;

  logic signed [WORD_W-1:0] in_w, out_w, stp, diff, off0, l_sub, l_int;
  logic signed [WORD_W-1:0] o1, r_int, r_sub, r_in, carry;

  always_comb begin
    in_w  = $signed({{(WORD_W-LEN_W){1'b0}}, in_len_i});
    out_w = $signed({{(WORD_W-LEN_W){1'b0}}, out_len_i});
    stp   = $signed(step_i);

    diff  = stp * (out_w - 1) - ((in_w - 1) <<< FRAC_W);
    off0  = half_tz(diff);

    l_int = '0;
    l_sub = -off0;
    if (l_sub < 0) begin
      l_int = l_int - 1;
      l_sub = l_sub + UNIT;
    end
    if (l_sub >= UNIT) begin
      l_int = l_int + 1;
      l_sub = l_sub - UNIT;
    end

    carry = (off0 != 0) ? WORD_W'(1) : '0;
    o1    = (UNIT - off0 + (out_w >>> 1) * stp)
            - (((in_w >>> 1) - OVL - carry + 1) <<< FRAC_W) + UNIT;
    r_int = unit_div_tz(o1);
    r_sub = o1 - (r_int <<< FRAC_W);
    r_in  = (in_w >>> 1) + OVL + carry;
    if (r_int[0]) begin
      r_int = r_int + 1;
      r_in  = r_in + 1;
    end

    left_o.int_off = l_int[INT_W-1:0];
    left_o.sub_off = l_sub[SUB_W-1:0];
    right_o        = '0;
    if (dual_i) begin
      left_o.in_len   = LEN_W'(in_len_i >> 1) + (LEN_W+1)'(OVL);
      left_o.out_len  = out_len_i >> 1;
      right_o.int_off = r_int[INT_W-1:0];
      right_o.sub_off = r_sub[SUB_W-1:0];
      right_o.in_len  = r_in[LEN_W:0];
      right_o.out_len = out_len_i >> 1;
    end else begin
      left_o.in_len  = {1'b0, in_len_i};
      left_o.out_len = out_len_i;
    end
    centre_nz_o = (off0 != 0);
  end
endmodule

// File: rtl/scl_tile_calc.sv
module scl_tile_calc
  import scl_tile_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [LEN_W-1:0]   in_len_i,
  input  logic [LEN_W-1:0]   out_len_i,
  input  logic               dual_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               err_o,
  output logic [WORD_W-1:0]  step_o,
  output logic [INT_W-1:0]   l_int_o,
  output logic [SUB_W-1:0]   l_sub_o,
  output logic [LEN_W:0]     l_in_o,
  output logic [LEN_W-1:0]   l_out_o,
  output logic [INT_W-1:0]   r_int_o,
  output logic [SUB_W-1:0]   r_sub_o,
  output logic [LEN_W:0]     r_in_o,
  output logic [LEN_W-1:0]   r_out_o
);
  typedef enum logic [1:0] {S_IDLE, S_DIV, S_FIN, S_ERR} state_t;

  state_t             state_q;
  logic [LEN_W-1:0]   in_q, out_q;
  logic               dual_q;
  logic [WORD_W-1:0]  step_q;

  // named internal events
  logic               accept_w, reject_w, div_go_w, div_valid_w;
  logic [WORD_W-1:0]  div_num_w, div_den_w, div_quo_w;
  tile_t              left_w, right_w;
  logic               centre_nz_w;

  assign accept_w  = (state_q == S_IDLE) && start_i;
  assign reject_w  = accept_w && (out_len_i < LEN_W'(2));
  assign div_go_w  = accept_w && !reject_w;
  assign div_num_w = (({{(WORD_W-LEN_W){1'b0}}, in_len_i} - 1) << FRAC_W)
                     + ({{(WORD_W-LEN_W){1'b0}}, out_len_i} - 2);
  assign div_den_w = {{(WORD_W-LEN_W){1'b0}}, out_len_i} - 1;

  scl_iter_div #(.W(WORD_W)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .go_i    (div_go_w),
    .num_i   (div_num_w),
    .den_i   (div_den_w),
    .quo_o   (div_quo_w),
    .valid_o (div_valid_w)
  );

  scl_phase_calc u_phase (
    .in_len_i    (in_q),
    .out_len_i   (out_q),
    .step_i      (step_q),
    .dual_i      (dual_q),
    .left_o      (left_w),
    .right_o     (right_w),
    .centre_nz_o (centre_nz_w)
  );

  assign busy_o = (state_q != S_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      in_q <= '0; out_q <= '0; dual_q <= 1'b0; step_q <= '0;
      done_o <= 1'b0; err_o <= 1'b0;
      step_o <= '0;
      l_int_o <= '0; l_sub_o <= '0; l_in_o <= '0; l_out_o <= '0;
      r_int_o <= '0; r_sub_o <= '0; r_in_o <= '0; r_out_o <= '0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      unique case (state_q)
        S_IDLE: if (accept_w) begin
          in_q    <= in_len_i;
          out_q   <= out_len_i;
          dual_q  <= dual_i;
          state_q <= reject_w ? S_ERR : S_DIV;
        end
        S_DIV: if (div_valid_w) begin
          step_q  <= div_quo_w;
          state_q <= S_FIN;
        end
        S_FIN: begin
          done_o  <= 1'b1;
          step_o  <= step_q;
          l_int_o <= left_w.int_off;  l_sub_o <= left_w.sub_off;
          l_in_o  <= left_w.in_len;   l_out_o <= left_w.out_len;
          r_int_o <= right_w.int_off; r_sub_o <= right_w.sub_off;
          r_in_o  <= right_w.in_len;  r_out_o <= right_w.out_len;
          state_q <= S_IDLE;
        end
        S_ERR: begin
          done_o  <= 1'b1;
          err_o   <= 1'b1;
          step_o  <= '0;
          l_int_o <= '0; l_sub_o <= '0; l_in_o <= '0; l_out_o <= '0;
          r_int_o <= '0; r_sub_o <= '0; r_in_o <= '0; r_out_o <= '0;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  AST_ERR_HAS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o && (step_o == '0) && (l_in_o == '0)); // R2
  AST_LEFT_SUB_NORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o) |-> (l_sub_o < (SUB_W'(1) << FRAC_W))); // R3
  AST_SINGLE_RIGHT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !dual_q) |-> (r_in_o == '0) && (r_int_o == '0) && (r_out_o == '0)); // R4
  AST_RIGHT_EVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && dual_q && !err_o) |-> !r_int_o[0]); // R6
  AST_RIGHT_IN_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && dual_q && !err_o) |->
      (r_in_o >= l_in_o + (LEN_W+1)'(centre_nz_w))); // R6
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o); // R8
  AST_BUSY_IGNORES_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !done_o) |=> $stable(in_q) && $stable(out_q)); // R8
  AST_HOLD_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(step_o) && $stable(l_sub_o) && $stable(r_sub_o)); // R9
endmodule

// File: tb/tb_scl_tile_calc.sv
module tb_scl_tile_calc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] in_len = '0, out_len = '0;
  logic        dual = 1'b0;
  logic        busy, done, err;
  logic [31:0] step;
  logic [15:0] l_int, l_out, r_int, r_out;
  logic [20:0] l_sub, r_sub;
  logic [16:0] l_in, r_in;

  always #2 clk = ~clk; // 250 MHz

  scl_tile_calc dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .in_len_i(in_len), .out_len_i(out_len), .dual_i(dual),
    .busy_o(busy), .done_o(done), .err_o(err), .step_o(step),
    .l_int_o(l_int), .l_sub_o(l_sub), .l_in_o(l_in), .l_out_o(l_out),
    .r_int_o(r_int), .r_sub_o(r_sub), .r_in_o(r_in), .r_out_o(r_out)
  );

  typedef struct {
    bit     err, dual;
    longint stp, li, ls, lin, lout, ri, rs, rin, rout;
  } exp_t;

  exp_t exp_q[$];
  exp_t last_exp;
  int   n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // reference model written from the requirement text
  function automatic exp_t model(input longint a, input longint b, input bit d);
    exp_t e;
    longint off, s, i, c, o, ri, rs, rin;
    e = '{default: 0};
    e.dual = d;
    if (b < 2) begin e.err = 1; return e; end
    e.stp = (32768 * (a - 1) + (b - 2)) / (b - 1);             // R1
    off = (e.stp * (b - 1) - 32768 * (a - 1)) / 2;             // truncating
    i = 0; s = -off;
    if (s < 0) begin i = i - 1; s = s + 32768; end             // R3
    if (s >= 32768) begin i = i + 1; s = s - 32768; end
    e.li = i & 16'hFFFF; e.ls = s & 21'h1FFFFF;                 // R7
    if (!d) begin
      e.lin = a; e.lout = b;                                    // R4
      return e;
    end
    c = (off != 0) ? 1 : 0;
    e.lin = a / 2 + 4; e.lout = b / 2; e.rout = b / 2;          // R5
    o  = 32768 - off + (b / 2) * e.stp - (a / 2 - 4 - c + 1) * 32768 + 32768;
    ri = o / 32768;
    rs = o - 32768 * ri;
    rin = a / 2 + 4 + c;
    if ((ri % 2) != 0) begin ri = ri + 1; rin = rin + 1; end    // R6
    e.ri = ri & 16'hFFFF; e.rs = rs & 21'h1FFFFF; e.rin = rin;
    return e;
  endfunction

  task automatic compare(input exp_t e);
    string sfx;
    sfx = e.dual ? "R5" : "R4";
    chk(err == e.err, "R2 err", err, e.err);
    chk(step == e.stp, "R1 step", step, e.stp);
    chk(l_int == e.li, "R3/R7 l_int", l_int, e.li);
    chk(l_sub == e.ls, "R3/R7 l_sub", l_sub, e.ls);
    chk(l_in == e.lin, {sfx, " l_in"}, l_in, e.lin);
    chk(l_out == e.lout, {sfx, " l_out"}, l_out, e.lout);
    chk(r_int == e.ri, "R6/R7 r_int", r_int, e.ri);
    chk(r_sub == e.rs, "R6/R7 r_sub", r_sub, e.rs);
    chk(r_in == e.rin, "R6 r_in", r_in, e.rin);
    chk(r_out == e.rout, {sfx, " r_out"}, r_out, e.rout);
  endtask

  // monitor: pops an expected item for every done pulse
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && done) begin
        if (exp_q.size() == 0) begin
          chk(0, "R8 unexpected result", 1, 0);
        end else begin
          last_exp = exp_q.pop_front();
          compare(last_exp);
        end
      end
    end
  end

  task automatic run(input int a, input int b, input bit d);
    while (busy) @(negedge clk);
    in_len = 16'(a); out_len = 16'(b); dual = d; start = 1'b1;
    exp_q.push_back(model(a, b, d));
    @(negedge clk);
    start = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (5) @(negedge clk);
    // R9: results held after the done pulse
    chk(step == last_exp.stp && l_sub == last_exp.ls && r_in == last_exp.rin,
        "R9 hold", step, last_exp.stp);
  endtask

  initial begin
    int seed;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && step == 0 && l_in == 0, "R8 reset", step, 0);
    rst_n = 1'b1;
    @(negedge clk);

    run(10, 20, 0);
    run(100, 250, 1);
    run(1, 1, 0);      // R2
    run(5, 0, 1);      // R2
    run(7, 7, 1);      // R6 odd right integer part
    run(1080, 2400, 1);
    run(1, 2, 0);
    run(2, 2, 0);
    run(720, 1080, 0);
    run(33, 64, 1);
    run(50, 20, 1);
    run(4000, 4001, 1);

    // R8: start pulse mid-computation is dropped
    while (busy) @(negedge clk);
    in_len = 16'd100; out_len = 16'd250; dual = 1'b1; start = 1'b1;
    exp_q.push_back(model(100, 250, 1));
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b1, "R8 busy", busy, 1);
    in_len = 16'd9; out_len = 16'd300; dual = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (60) @(negedge clk);
    chk(!busy && exp_q.size() == 0, "R8 no second result", busy, 0);

    seed = 12345;
    for (int k = 0; k < 16; k++) begin
      int a, b;
      seed = seed * 1103515245 + 12345;
      a = 1 + ((seed >>> 8) & 32'h7FF);
      seed = seed * 1103515245 + 12345;
      b = a + 1 + ((seed >>> 8) & 32'h7FF);
      run(a, b, k[0]);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule